// File: doc/BRIEF.md
# Multiphase Phase Shedding Manager

This block keeps the membership of a current-sharing output rail built from several parallel power stages. A host issues add or drop commands, each naming one member, to turn phases off at light load and back on when the load grows. The block holds the set of active members and derives three things from it: how many members are active, which active member acts as the timing reference, and the phase slot each active member uses. Slot k of n corresponds to a phase offset of k × 360°/n.

Before the rail reports power-good, every configured member counts as active and commands are ignored. After power-good, any active member may be dropped, the reference included. The reference is always the lowest-indexed active member, and every change in membership renumbers the slots. A fault shuts the rail down. Once the fault clears, the block issues one restart strobe to all members together, makes every configured member active again, and waits for power-good before it accepts commands.

Top module: `phase_shed_mgr`

## Requirements
- R1: While waiting for power-good, both after reset and after a restart, `active_mask` equals `cfg_mask` and add/drop commands have no effect.
- R2: After power-good, a drop command (`cmd_drop`=1) naming an active member clears that member's bit in `active_mask` on the cycle after the command, as long as another member stays active. The reference member can be dropped this way.
- R3: After power-good, an add command (`cmd_drop`=0) naming a configured member that is inactive sets its bit in `active_mask` on the cycle after the command.
- R4: A drop of an inactive member, an add of an active member, or an add of a member whose `cfg_mask` bit is 0 leaves `active_mask` unchanged and raises no error.
- R5: A drop that names the only active member is rejected. `active_mask` stays unchanged and `cmd_err` is high for exactly one cycle, the cycle after the command.
- R6: `act_count` equals the number of set bits in `active_mask`, one cycle after `active_mask` takes that value.
- R7: `ref_idx` is the index of the lowest set bit of `active_mask`, with the same one-cycle lag. When the reference is dropped, the role passes to the next lowest active member.
- R8: The slot of member i sits in `slot_flat[i*IDX_W +: IDX_W]`. For an active member it equals the number of active members with an index below i. For an inactive member it is 0. It has the same one-cycle lag.
- R9: `fault` high moves the rail to shutdown, and commands are ignored while shut down. The first cycle with `fault_clr` high and `fault` low makes every configured member active and pulses `restart` on the following cycle. The block then waits for power-good again.
- R10: `restart` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mask | input | N_MEMBERS | Members configured in the rail (nonzero) |
| cmd_valid | input | 1 | Host command strobe |
| cmd_idx | input | IDX_W | Member named by the command |
| cmd_drop | input | 1 | 1 = drop member, 0 = add member |
| pgood | input | 1 | Rail power-good |
| fault | input | 1 | Fault forcing rail shutdown |
| fault_clr | input | 1 | Fault has cleared |
| active_mask | output | N_MEMBERS | Active members |
| act_count | output | CNT_W | Number of active members |
| ref_idx | output | IDX_W | Reference member index |
| slot_flat | output | N_MEMBERS*IDX_W | Per-member phase slot, packed |
| cmd_err | output | 1 | Rejected last-member drop |
| restart | output | 1 | Common restart strobe |

## Verification
The assertions check on every cycle that the count and reference match the previous cycle's mask and that the reference member's slot is zero. They also check that a rejected command leaves the mask untouched, that a restart brings back the configured set, and that the restart strobe lasts a single cycle. Only the bench scenarios show the command-level behaviour. These are gating before power-good, ignoring commands during a fault, the add and drop rules for every member under every reachable four-member mask, and the complete slot renumbering after each change.

// File: rtl/psm_pkg.sv
package psm_pkg;

    localparam int PSM_MAX_MEMBERS = 16;

    typedef enum logic [1:0] {
        RS_RAMP  = 2'd0,
        RS_RUN   = 2'd1,
        RS_FAULT = 2'd2
    } rail_state_e;

    typedef enum logic [1:0] {
        CO_NONE   = 2'd0,
        CO_APPLY  = 2'd1,
        CO_REJECT = 2'd2
    } cmd_outcome_e;

    typedef struct packed {
        cmd_outcome_e                 outcome;
        logic [PSM_MAX_MEMBERS-1:0]   next_mask;
    } cmd_result_t;

    // Index of the lowest set bit; 0 when the vector is empty.
    function automatic logic [3:0] lowest_set(input logic [PSM_MAX_MEMBERS-1:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int j = PSM_MAX_MEMBERS - 1; j >= 0; j--) begin
            if (v[j]) r = 4'(j);
        end
        return r;
    endfunction

    // Number of set bits strictly below position pos.
    function automatic logic [4:0] count_below(input logic [PSM_MAX_MEMBERS-1:0] v,
                                               input int pos);
        logic [4:0] c;
        c = 5'd0;
        for (int j = 0; j < PSM_MAX_MEMBERS; j++) begin
            if (j < pos) c = c + 5'(v[j]);
        end
        return c;
    endfunction

endpackage

// File: rtl/psm_cmd_eval.sv
module psm_cmd_eval
    import psm_pkg::*;
#(
    parameter int N_MEMBERS = 4,
    localparam int IDX_W = $clog2(N_MEMBERS)
) (
    input  logic [N_MEMBERS-1:0] active,
    input  logic [N_MEMBERS-1:0] cfg,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 drop,
    output cmd_result_t          result
);
    logic [N_MEMBERS-1:0] sel;

    always_comb begin
        sel = {{(N_MEMBERS-1){1'b0}}, 1'b1} << idx;
        result.outcome   = CO_NONE;
        result.next_mask = PSM_MAX_MEMBERS'(active);
        if (drop) begin
            if ((active & sel) == '0) begin
                result.outcome = CO_NONE;
            end else if (active == sel) begin
                result.outcome = CO_REJECT;
            end else begin
                result.outcome   = CO_APPLY;
                result.next_mask = PSM_MAX_MEMBERS'(active & ~sel);
            end
        end else begin
            if ((cfg & sel) == '0 || (active & sel) != '0) begin
                result.outcome = CO_NONE;
            end else begin
                result.outcome   = CO_APPLY;
                result.next_mask = PSM_MAX_MEMBERS'(active | sel);
            end
        end
    end
endmodule

// File: rtl/psm_rail_ctl.sv
module psm_rail_ctl
    import psm_pkg::*;
#(
    parameter int N_MEMBERS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MEMBERS-1:0] cfg_mask,
    input  logic                 cmd_valid,
    input  cmd_result_t          cmd_res,
    input  logic                 pgood,
    input  logic                 fault,
    input  logic                 fault_clr,
    output logic [N_MEMBERS-1:0] active_mask,
    output logic                 cmd_err,
    output logic                 restart
);
    rail_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RS_RAMP;
            active_mask <= cfg_mask;
            cmd_err     <= 1'b0;
            restart     <= 1'b0;
        end else begin
            cmd_err <= 1'b0;
            restart <= 1'b0;
            unique case (state_q)
                RS_RAMP: begin
                    // All configured phases ramp together; commands are gated.
                    active_mask <= cfg_mask;
                    if (fault)      state_q <= RS_FAULT;
                    else if (pgood) state_q <= RS_RUN;
                end
                RS_RUN: begin
                    if (fault) begin
                        state_q <= RS_FAULT;
                    end else if (cmd_valid) begin
                        if (cmd_res.outcome == CO_APPLY)
                            active_mask <= cmd_res.next_mask[N_MEMBERS-1:0];
                        else if (cmd_res.outcome == CO_REJECT)
                            cmd_err <= 1'b1;
                    end
                end
                RS_FAULT: begin
                    if (fault_clr && !fault) begin
                        state_q     <= RS_RAMP;
                        active_mask <= cfg_mask;
                        restart     <= 1'b1;
                    end
                end
                default: state_q <= RS_RAMP;
            endcase
        end
    end
endmodule

// File: rtl/psm_rank_calc.sv
module psm_rank_calc
    import psm_pkg::*;
#(
    parameter int N_MEMBERS = 4,
    localparam int IDX_W = $clog2(N_MEMBERS),
    localparam int CNT_W = $clog2(N_MEMBERS + 1)
) (
    input  logic [N_MEMBERS-1:0]       mask,
    output logic [CNT_W-1:0]           count,
    output logic [IDX_W-1:0]           ref_idx,
    output logic [N_MEMBERS*IDX_W-1:0] slots
);
    logic [PSM_MAX_MEMBERS-1:0] ext;
    logic [4:0]                 total;

    assign ext     = PSM_MAX_MEMBERS'(mask);
    assign total   = count_below(ext, PSM_MAX_MEMBERS);
    assign count   = CNT_W'(total);
    assign ref_idx = IDX_W'(lowest_set(ext));

    for (genvar i = 0; i < N_MEMBERS; i++) begin : g_slot
        logic [4:0] rank;
        assign rank = count_below(ext, i);
        assign slots[i*IDX_W +: IDX_W] = mask[i] ? IDX_W'(rank) : '0;
    end
endmodule

// File: rtl/psm_out_reg.sv
module psm_out_reg #(
    parameter int N_MEMBERS = 4,
    localparam int IDX_W = $clog2(N_MEMBERS),
    localparam int CNT_W = $clog2(N_MEMBERS + 1)
) (
    input  logic                       clk,
    input  logic [CNT_W-1:0]           count_d,
    input  logic [IDX_W-1:0]           ref_d,
    input  logic [N_MEMBERS*IDX_W-1:0] slots_d,
    output logic [CNT_W-1:0]           count_q,
    output logic [IDX_W-1:0]           ref_q,
    output logic [N_MEMBERS*IDX_W-1:0] slots_q
);
    // No reset branch: during reset the top feeds values derived from cfg_mask.
    always_ff @(posedge clk) begin
        count_q <= count_d;
        ref_q   <= ref_d;
        slots_q <= slots_d;
    end
endmodule

// File: rtl/phase_shed_mgr.sv
module phase_shed_mgr
    import psm_pkg::*;
#(
    parameter int N_MEMBERS = 4,
    localparam int IDX_W = $clog2(N_MEMBERS),
    localparam int CNT_W = $clog2(N_MEMBERS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_MEMBERS-1:0]       cfg_mask,
    input  logic                       cmd_valid,
    input  logic [IDX_W-1:0]           cmd_idx,
    input  logic                       cmd_drop,
    input  logic                       pgood,
    input  logic                       fault,
    input  logic                       fault_clr,
    output logic [N_MEMBERS-1:0]       active_mask,
    output logic [CNT_W-1:0]           act_count,
    output logic [IDX_W-1:0]           ref_idx,
    output logic [N_MEMBERS*IDX_W-1:0] slot_flat,
    output logic                       cmd_err,
    output logic                       restart
);
    cmd_result_t                cmd_res;
    logic [N_MEMBERS-1:0]       calc_in;
    logic [CNT_W-1:0]           count_c;
    logic [IDX_W-1:0]           ref_c;
    logic [N_MEMBERS*IDX_W-1:0] slots_c;

    psm_cmd_eval #(.N_MEMBERS(N_MEMBERS)) eval_i (
        .active (active_mask),
        .cfg    (cfg_mask),
        .idx    (cmd_idx),
        .drop   (cmd_drop),
        .result (cmd_res)
    );

    psm_rail_ctl #(.N_MEMBERS(N_MEMBERS)) ctl_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_mask    (cfg_mask),
        .cmd_valid   (cmd_valid),
        .cmd_res     (cmd_res),
        .pgood       (pgood),
        .fault       (fault),
        .fault_clr   (fault_clr),
        .active_mask (active_mask),
        .cmd_err     (cmd_err),
        .restart     (restart)
    );

    assign calc_in = rst ? cfg_mask : active_mask;

    psm_rank_calc #(.N_MEMBERS(N_MEMBERS)) rank_i (
        .mask    (calc_in),
        .count   (count_c),
        .ref_idx (ref_c),
        .slots   (slots_c)
    );

    psm_out_reg #(.N_MEMBERS(N_MEMBERS)) oreg_i (
        .clk     (clk),
        .count_d (count_c),
        .ref_d   (ref_c),
        .slots_d (slots_c),
        .count_q (act_count),
        .ref_q   (ref_idx),
        .slots_q (slot_flat)
    );
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
    parameter int N_MEMBERS = 4,
    localparam int IDX_W = $clog2(N_MEMBERS),
    localparam int CNT_W = $clog2(N_MEMBERS + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [N_MEMBERS-1:0]       cfg_mask,
    input logic [N_MEMBERS-1:0]       active_mask,
    input logic [CNT_W-1:0]           act_count,
    input logic [IDX_W-1:0]           ref_idx,
    input logic [N_MEMBERS*IDX_W-1:0] slot_flat,
    input logic                       cmd_err,
    input logic                       restart
);
    logic                 armed;
    logic [N_MEMBERS-1:0] prev_act;
    logic [N_MEMBERS-1:0] below_ref;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
        prev_act <= active_mask;
    end

    always_comb below_ref = (N_MEMBERS'(1) << ref_idx) - N_MEMBERS'(1);

    a_r6_count_tracks: assert property (@(posedge clk) disable iff (rst)
        armed |-> (32'(act_count) == $countones(prev_act)));

    a_r7_ref_lowest: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_act != '0) |-> (prev_act[ref_idx] && ((prev_act & below_ref) == '0)));

    a_r8_ref_slot_zero: assert property (@(posedge clk) disable iff (rst)
        armed |-> (slot_flat[ref_idx*IDX_W +: IDX_W] == '0));

    a_r5_reject_holds: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (active_mask == $past(active_mask)));

    a_r9_restart_all: assert property (@(posedge clk) disable iff (rst)
        restart |-> (active_mask == $past(cfg_mask)));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);
endmodule

bind phase_shed_mgr psm_checker #(.N_MEMBERS(N_MEMBERS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_mask    (cfg_mask),
    .active_mask (active_mask),
    .act_count   (act_count),
    .ref_idx     (ref_idx),
    .slot_flat   (slot_flat),
    .cmd_err     (cmd_err),
    .restart     (restart)
);

// File: tb/phase_shed_mgr_tb.sv
module phase_shed_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int IW = 2;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  cfg_mask = 4'b1111;
    logic          cmd_valid = 1'b0;
    logic [IW-1:0] cmd_idx = '0;
    logic          cmd_drop = 1'b0;
    logic          pgood = 1'b0;
    logic          fault = 1'b0;
    logic          fault_clr = 1'b0;
    logic [N-1:0]  active_mask;
    logic [CW-1:0] act_count;
    logic [IW-1:0] ref_idx;
    logic [N*IW-1:0] slot_flat;
    logic          cmd_err;
    logic          restart;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_shed_mgr #(.N_MEMBERS(N)) dut_i (
        .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cmd_valid(cmd_valid),
        .cmd_idx(cmd_idx), .cmd_drop(cmd_drop), .pgood(pgood), .fault(fault),
        .fault_clr(fault_clr), .active_mask(active_mask), .act_count(act_count),
        .ref_idx(ref_idx), .slot_flat(slot_flat), .cmd_err(cmd_err), .restart(restart)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int e_count(input logic [N-1:0] m);
        int c = 0;
        for (int j = 0; j < N; j++) c += int'(m[j]);
        return c;
    endfunction

    function automatic int e_ref(input logic [N-1:0] m);
        for (int j = 0; j < N; j++) if (m[j]) return j;
        return 0;
    endfunction

    function automatic int e_slot(input logic [N-1:0] m, input int i);
        int c = 0;
        if (!m[i]) return 0;
        for (int j = 0; j < i; j++) c += int'(m[j]);
        return c;
    endfunction

    // Called one cycle after active_mask settles at m.
    task automatic check_derived(input logic [N-1:0] m);
        check("R6 count", int'(act_count), e_count(m));
        check("R7 reference", int'(ref_idx), e_ref(m));
        for (int i = 0; i < N; i++)
            check("R8 slot", int'(slot_flat[i*IW +: IW]), e_slot(m, i));
    endtask

    task automatic apply_cmd(input int idx, input bit drop);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_idx   = IW'(idx);
        cmd_drop  = drop;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_restart();
        fault = 1'b1;
        pgood = 1'b0;
        @(negedge clk);
        fault     = 1'b0;
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check("R9 restart pulse", int'(restart), 1);
        check("R9 configured set", int'(active_mask), int'(cfg_mask));
        @(negedge clk);
        check("R10 restart single", int'(restart), 0);
        pgood = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        check("R1 reset mask", int'(active_mask), 15);
        check("R5 reset err", int'(cmd_err), 0);
        check("R10 reset restart", int'(restart), 0);
        check_derived(4'b1111);
        rst = 1'b0;

        // R1: drop before power-good is ignored
        apply_cmd(0, 1'b1);
        check("R1 gated drop", int'(active_mask), 15);
        @(negedge clk);
        check_derived(4'b1111);
        pgood = 1'b1;
        @(negedge clk);

        // R2: drop the reference, role passes on
        apply_cmd(0, 1'b1);
        check("R2 drop ref", int'(active_mask), 4'b1110);
        @(negedge clk);
        check("R7 new ref", int'(ref_idx), 1);
        check_derived(4'b1110);
        // R3: add it back
        apply_cmd(0, 1'b0);
        check("R3 add back", int'(active_mask), 15);
        @(negedge clk);
        check_derived(4'b1111);

        // R9: commands ignored while shut down
        fault = 1'b1;
        pgood = 1'b0;
        @(negedge clk);
        apply_cmd(2, 1'b1);
        check("R9 ignored in fault", int'(active_mask), 15);
        do_restart();

        // R4 and R1: partial configuration, unconfigured add ignored
        cfg_mask = 4'b1011;
        do_restart();
        check("R1 partial cfg", int'(active_mask), 4'b1011);
        apply_cmd(2, 1'b0);
        check("R4 unconfigured add", int'(active_mask), 4'b1011);
        check("R4 unconfigured err", int'(cmd_err), 0);
        @(negedge clk);
        check_derived(4'b1011);
        cfg_mask = 4'b1111;
        do_restart();

        // Sweep: every reachable mask, every member, both operations
        for (int m = 1; m < 16; m++) begin
            for (int idx = 0; idx < N; idx++) begin
                for (int op = 0; op < 2; op++) begin
                    logic [N-1:0] mm;
                    logic [N-1:0] sel;
                    logic [N-1:0] exp_m;
                    bit           exp_e;
                    mm  = N'(m);
                    sel = N'(1) << idx;
                    do_restart();
                    for (int b = 0; b < N; b++)
                        if (!mm[b]) apply_cmd(b, 1'b1);
                    @(negedge clk);
                    check("R2 built mask", int'(active_mask), int'(mm));
                    check_derived(mm);
                    exp_m = mm;
                    exp_e = 1'b0;
                    if (op == 1) begin
                        if (!mm[idx])          exp_m = mm;
                        else if (mm == sel)    exp_e = 1'b1;
                        else                   exp_m = mm & ~sel;
                    end else begin
                        exp_m = mm | sel;
                    end
                    apply_cmd(idx, op == 1);
                    check(op == 1 ? "R2 R4 R5 drop mask" : "R3 R4 add mask",
                          int'(active_mask), int'(exp_m));
                    check("R5 err pulse", int'(cmd_err), int'(exp_e));
                    @(negedge clk);
                    check("R5 err cleared", int'(cmd_err), 0);
                    check_derived(exp_m);
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule